// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This is a passive observer that watches the command and address pins of an SDRAM device. It keeps a small state machine for every bank and reports any command that the current bank states forbid. It drives nothing on the memory bus. Each rising clock edge samples chip select, the row strobe, the column strobe, write enable, the bank address and address bit 10. The monitor turns these into a command and checks the command against the bank states.

Two busy conditions are judged in detail:

- **Write burst with auto-precharge.** The bank stays busy through the burst and then through the write-recovery wait.
- **Auto-refresh.** Every bank is busy until the row-cycle time has passed.

Idle and row-open tracking is kept only so that these two conditions can be entered. Commands are not flagged outside them.

The monitor reports three things:

- A one-cycle illegal pulse, with the offending command and bank alongside it.
- A sticky error flag that only reset clears.
- The registered command code and the packed per-bank state, for waveform and scoreboard use.

Timing is set in clock cycles through the parameters `BURST_LEN`, `T_DPL`, `T_RRD` and `T_RC`.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Each edge's command is decoded and shown on `cmd_code` after that edge. Chip select high gives DESL=0 whatever the other lines are. With chip select low, the (row, column, write) strobe levels decode as follows:
  - HHH = NOP=1
  - HHL = BST=2
  - HLH = READ=3
  - HLL = WRITE=4
  - LHH = ACT=5
  - LHL = PRE=6
  - LLH = REF=7
  - LLL = MRS=8
- R2: Bank i's state sits in `bank_state[3i+2:3i]` with codes IDLE=0, OPEN=1, WBURST=2, RECOV=3, REFR=4. ACT to an idle bank makes it OPEN. PRE with a10=0 closes the addressed open bank. PRE with a10=1 closes every open bank.
- R3: WRITE with a10=1 to an open bank at edge k has the following effect on that bank:
  - It shows WBURST after edges k to k+BURST_LEN-2.
  - It shows RECOV up to edge k+BURST_LEN+T_DPL-3.
  - It shows IDLE from edge k+BURST_LEN+T_DPL-2 onward.
- R4: While any bank is WBURST or RECOV, DESL and NOP are legal, and BST, REF and MRS are illegal.
- R5: While any bank is WBURST or RECOV, READ, WRITE and PRE with a10=0 are illegal when aimed at such a bank and legal when aimed at another bank. PRE with a10=1 is illegal.
- R6: While any bank is WBURST or RECOV, ACT is illegal in two cases:
  - It is aimed at such a bank.
  - It comes fewer than `T_RRD` edges after the last accepted ACT.
- R7: REF with every bank idle at edge r puts all banks in REFR. All banks return to IDLE at edge r+T_RC-1, so the command at edge r+T_RC finds them idle.
- R8: While the banks are in REFR, DESL, NOP and BST are legal and every other command is illegal, whatever bank it names.
- R9: An illegal command at an edge raises `illegal` for exactly the cycle after that edge, with `ill_cmd` and `ill_bank` giving its code and bank. `err_sticky` rises at the same time and stays high until reset.
- R10: An illegal command changes no bank state and does not restart the `T_RRD` count.
- R11: Synchronous reset puts every bank in IDLE, clears `illegal` and `err_sticky`, and sets `cmd_code` to DESL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-banks select) |
| cmd_code | output | 4 | Registered decoded command |
| illegal | output | 1 | One-cycle pulse for an illegal command |
| ill_cmd | output | 4 | Code of the last illegal command |
| ill_bank | output | BA_W | Bank named by the last illegal command |
| err_sticky | output | 1 | Set by any illegal command, cleared by reset |
| bank_state | output | 3*NBANK | Packed per-bank state codes |

## Verification
The same commands are sent in three contexts: all banks idle, a write burst in flight on one bank with a second bank open, and a refresh in progress. Comparing the three shows which commands are judged against the targeted bank and which against every bank.

A READ, PRE or ACT is aimed once at the busy bank and once at another bank, and also in the burst phase and the recovery phase. These runs separate per-bank rules from global ones and show whether the recovery phase is still treated as busy.

Two back-to-back ACTs, with a rejected one between them, show whether the row-to-row count starts from the last accepted activate.

Walking the burst and refresh windows edge by edge pins down the exact cycle in which each bank becomes idle again.

// File: rtl/sdcm_pkg.sv
`timescale 1ns/1ps
package sdcm_pkg;

  typedef enum logic [3:0] {
    CMD_DESL = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_BST  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_ACT  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_REF  = 4'd7,
    CMD_MRS  = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE   = 3'd0,
    BS_OPEN   = 3'd1,
    BS_WBURST = 3'd2,
    BS_RECOV  = 3'd3,
    BS_REFR   = 3'd4
  } bst_e;

  // Command from the four active-low control lines.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_DESL;
    case ({ras_n, cas_n, we_n})
      3'b111:  return CMD_NOP;
      3'b110:  return CMD_BST;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b011:  return CMD_ACT;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      default: return CMD_MRS;
    endcase
  endfunction

  // A bank still owned by a write burst with auto-precharge.
  function automatic logic wr_busy(input bst_e s);
    return (s == BS_WBURST) || (s == BS_RECOV);
  endfunction

  // Largest of three cycle counts, used to size the bank counter.
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Edges from a write with auto-precharge until the bank reads idle.
  function automatic int wr_idle_edge(input int bl, input int dpl);
    return bl + dpl - 2;
  endfunction

endpackage

// File: rtl/sdcm_decode.sv
`timescale 1ns/1ps
module sdcm_decode
  import sdcm_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

endmodule

// File: rtl/sdcm_bank.sv
`timescale 1ns/1ps
module sdcm_bank
  import sdcm_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_DPL     = 2,
  parameter int T_RC      = 6,
  parameter int CW        = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic do_open,
  input  logic do_close,
  input  logic do_wrap,
  input  logic do_refr,
  output bst_e state
);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BS_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        BS_IDLE: begin
          if (do_refr) begin
            state <= BS_REFR;
            cnt   <= CW'(T_RC - 1);
          end else if (do_open) begin
            state <= BS_OPEN;
          end
        end
        BS_OPEN: begin
          if (do_wrap) begin
            state <= BS_WBURST;
            cnt   <= CW'(BURST_LEN - 1);
          end else if (do_close) begin
            state <= BS_IDLE;
          end
        end
        BS_WBURST: begin
          if (last) begin
            state <= BS_RECOV;
            cnt   <= CW'(T_DPL - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        BS_RECOV, BS_REFR: begin
          if (last) begin
            state <= BS_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= BS_IDLE;
      endcase
    end
  end

  // R3: a burst only leaves through write recovery.
  assert_wburst_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (state == BS_WBURST) |=> (state == BS_WBURST || state == BS_RECOV));

  // R3: recovery only ends in idle.
  assert_recov_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (state == BS_RECOV) |=> (state == BS_RECOV || state == BS_IDLE));

  // R3: a burst starts only on an open bank.
  assert_wburst_entry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(state == BS_WBURST) |-> ($past(state) == BS_OPEN));

  // R7: refresh only ends in idle.
  assert_refr_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state == BS_REFR) |=> (state == BS_REFR || state == BS_IDLE));

endmodule

// File: rtl/sdcm_rules.sv
`timescale 1ns/1ps
module sdcm_rules
  import sdcm_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] tgt,
  input  logic            a10,
  input  bst_e            st [NBANK],
  input  logic            rrd_met,
  output logic            bad
);

  logic wr_any;
  logic ref_any;
  logic tgt_busy;

  always_comb begin
    wr_any  = 1'b0;
    ref_any = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      wr_any  = wr_any | wr_busy(st[i]);
      ref_any = ref_any | (st[i] == BS_REFR);
    end
    tgt_busy = wr_busy(st[tgt]);
  end

  always_comb begin
    bad = 1'b0;
    if (ref_any) begin
      bad = !(cmd == CMD_DESL || cmd == CMD_NOP || cmd == CMD_BST);
    end else if (wr_any) begin
      case (cmd)
        CMD_BST, CMD_REF, CMD_MRS: bad = 1'b1;
        CMD_RD, CMD_WR:            bad = tgt_busy;
        CMD_PRE:                   bad = a10 | tgt_busy;
        CMD_ACT:                   bad = tgt_busy | !rrd_met;
        default:                   bad = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdcm_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int BURST_LEN = 4,
  parameter int T_DPL     = 2,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 6,
  localparam int BA_W     = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic [3:0]           cmd_code,
  output logic                 illegal,
  output logic [3:0]           ill_cmd,
  output logic [BA_W-1:0]      ill_bank,
  output logic                 err_sticky,
  output logic [3*NBANK-1:0]   bank_state
);

  localparam int CW = $clog2(max3(BURST_LEN, T_DPL, T_RC) + 1);
  localparam int RW = $clog2(T_RRD + 1);

  cmd_e            dec_cmd;
  bst_e            st [NBANK];
  logic            cmd_bad;
  logic            accept;
  logic            all_idle;
  logic            act_taken;
  logic            rrd_met;
  logic [RW-1:0]   rrd_cnt;
  logic [NBANK-1:0] ref_vec;

  cmd_e            cmd_q;
  cmd_e            bad_cmd_q;
  logic [BA_W-1:0] bad_bank_q;
  logic            illegal_q;
  logic            err_q;

  sdcm_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (dec_cmd)
  );

  sdcm_rules #(.NBANK(NBANK), .BA_W(BA_W)) u_rules (
    .cmd    (dec_cmd),
    .tgt    (ba),
    .a10    (a10),
    .st     (st),
    .rrd_met(rrd_met),
    .bad    (cmd_bad)
  );

  assign accept    = !cmd_bad;
  assign rrd_met   = (rrd_cnt == '0);
  assign act_taken = accept && (dec_cmd == CMD_ACT) && (st[ba] == BS_IDLE);

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NBANK; i++) all_idle = all_idle & (st[i] == BS_IDLE);
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(g));

    sdcm_bank #(
      .BURST_LEN(BURST_LEN),
      .T_DPL    (T_DPL),
      .T_RC     (T_RC),
      .CW       (CW)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .do_open (accept && dec_cmd == CMD_ACT && hit),
      .do_close(accept && dec_cmd == CMD_PRE && (a10 || hit)),
      .do_wrap (accept && dec_cmd == CMD_WR && a10 && hit),
      .do_refr (accept && dec_cmd == CMD_REF && all_idle),
      .state   (st[g])
    );

    assign bank_state[3*g +: 3] = st[g];
    assign ref_vec[g]           = (st[g] == BS_REFR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= CMD_DESL;
      bad_cmd_q  <= CMD_DESL;
      bad_bank_q <= '0;
      illegal_q  <= 1'b0;
      err_q      <= 1'b0;
      rrd_cnt    <= '0;
    end else begin
      cmd_q     <= dec_cmd;
      illegal_q <= cmd_bad;
      err_q     <= err_q | cmd_bad;
      if (cmd_bad) begin
        bad_cmd_q  <= dec_cmd;
        bad_bank_q <= ba;
      end
      if (act_taken)          rrd_cnt <= RW'(T_RRD - 1);
      else if (rrd_cnt != '0) rrd_cnt <= rrd_cnt - RW'(1);
    end
  end

  assign cmd_code   = cmd_q;
  assign illegal    = illegal_q;
  assign ill_cmd    = bad_cmd_q;
  assign ill_bank   = bad_bank_q;
  assign err_sticky = err_q;

  // R9: the pulse always comes with the sticky flag.
  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> err_sticky);

  // R9: the sticky flag never drops without reset.
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  // R4: deselect and no-op are never reported.
  assert_quiet_cmds_R4: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (ill_cmd != CMD_DESL && ill_cmd != CMD_NOP));

  // R7: refresh holds every bank or none.
  assert_refresh_all_R7: assert property (@(posedge clk) disable iff (rst)
    (|ref_vec) |-> (&ref_vec));

  // R7: refresh is entered only from an all-idle device.
  assert_refresh_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_vec[0]) |-> $past(all_idle));

  // R6: the row-to-row count stays inside its window.
  assert_rrd_window_R6: assert property (@(posedge clk) disable iff (rst)
    rrd_cnt <= RW'(T_RRD - 1));

  // R10: a flagged command leaves the row-to-row count running down.
  assert_rrd_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_bad && rrd_cnt != '0) |=> (rrd_cnt == $past(rrd_cnt) - RW'(1)));

endmodule

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;

  localparam int NB  = 4;
  localparam int BL  = 4;
  localparam int DPL = 2;
  localparam int RRD = 2;
  localparam int RC  = 6;

  localparam logic [3:0] P_DESL = 4'b1000, P_NOP = 4'b0111, P_BST = 4'b0110,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_ACT = 4'b0011,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

  localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_WR = 4,
                 C_ACT = 5, C_PRE = 6, C_REF = 7, C_MRS = 8;
  localparam int S_IDLE = 0, S_OPEN = 1, S_WB = 2, S_RC = 3, S_RF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [3:0] cmd_code, ill_cmd;
  logic illegal, err_sticky;
  logic [1:0] ill_bank;
  logic [3*NB-1:0] bank_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(
    .NBANK(NB), .BURST_LEN(BL), .T_DPL(DPL), .T_RRD(RRD), .T_RC(RC)
  ) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .cmd_code(cmd_code),
    .illegal(illegal), .ill_cmd(ill_cmd), .ill_bank(ill_bank),
    .err_sticky(err_sticky), .bank_state(bank_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bst(input int i);
    return int'((bank_state >> (3 * i)) & 12'h7);
  endfunction

  // Burst window: state seen after the j-th edge following the write.
  function automatic int wr_exp(input int j);
    if (j < BL - 1) return S_WB;
    if (j < BL + DPL - 2) return S_RC;
    return S_IDLE;
  endfunction

  // Drive one command and wait until its edge has been registered.
  task automatic issue(input logic [3:0] p, input int b, input bit a);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba  = 2'(b);
    a10 = a;
    @(negedge clk);
  endtask

  task automatic nop();
    issue(P_NOP, 0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic flag_chk(input string req, input int exp_ill,
                          input int exp_cmd, input int exp_bank);
    chk({req, " pulse"}, int'(illegal), exp_ill);
    if (exp_ill == 1) begin
      chk({req, " ill_cmd"}, int'(ill_cmd), exp_cmd);
      chk({req, " ill_bank"}, int'(ill_bank), exp_bank);
      chk({req, " sticky"}, int'(err_sticky), 1);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 bank_state", int'(bank_state), 0);
    chk("R11 illegal", int'(illegal), 0);
    chk("R11 err_sticky", int'(err_sticky), 0);
    chk("R11 cmd_code", int'(cmd_code), C_DESL);
  endtask

  task automatic t_decode();
    do_reset();
    issue(4'b1000, 0, 1'b0); chk("R1 deselect low lines", int'(cmd_code), C_DESL);
    issue(4'b1111, 0, 1'b0); chk("R1 deselect high lines", int'(cmd_code), C_DESL);
    nop();                   chk("R1 nop", int'(cmd_code), C_NOP);
    issue(P_BST, 0, 1'b0);   chk("R1 bst", int'(cmd_code), C_BST);
    issue(P_RD, 0, 1'b0);    chk("R1 read", int'(cmd_code), C_RD);
    issue(P_WR, 0, 1'b0);    chk("R1 write", int'(cmd_code), C_WR);
    issue(P_MRS, 0, 1'b0);   chk("R1 mrs", int'(cmd_code), C_MRS);
    issue(P_ACT, 1, 1'b0);   chk("R1 act", int'(cmd_code), C_ACT);
    issue(P_PRE, 1, 1'b0);   chk("R1 pre", int'(cmd_code), C_PRE);
    issue(P_REF, 0, 1'b0);   chk("R1 ref", int'(cmd_code), C_REF);
    chk("R1 idle traffic unflagged", int'(err_sticky), 0);
  endtask

  task automatic t_open_close();
    do_reset();
    issue(P_ACT, 1, 1'b0); chk("R2 act bank1", bst(1), S_OPEN);
    nop();
    issue(P_ACT, 2, 1'b0); chk("R2 act bank2", bst(2), S_OPEN);
    issue(P_PRE, 1, 1'b0);
    chk("R2 pre bank1", bst(1), S_IDLE);
    chk("R2 pre spares bank2", bst(2), S_OPEN);
    issue(P_ACT, 0, 1'b0);
    issue(P_PRE, 3, 1'b1); chk("R2 pre-all", int'(bank_state), 0);
  endtask

  task automatic t_wburst();
    do_reset();
    issue(P_ACT, 0, 1'b0);
    nop();
    issue(P_WR, 0, 1'b1);
    for (int j = 0; j <= BL + DPL - 1; j++) begin
      chk($sformatf("R3 bank0 state edge +%0d", j), bst(0), wr_exp(j));
      nop();
    end
    chk("R3 quiet burst", int'(err_sticky), 0);
  endtask

  task automatic t_same_bank();
    do_reset();
    issue(P_ACT, 0, 1'b0); nop();
    issue(P_ACT, 1, 1'b0); nop();
    issue(P_WR, 0, 1'b1);                       // edge k
    issue(P_RD, 0, 1'b0);                       // k+1
    flag_chk("R5 read busy bank", 1, C_RD, 0);
    chk("R10 bank0 kept in burst", bst(0), S_WB);
    issue(P_RD, 1, 1'b0);                       // k+2
    flag_chk("R5 read other bank", 0, 0, 0);
    chk("R9 sticky held", int'(err_sticky), 1);
    issue(P_WR, 1, 1'b0);                       // k+3
    flag_chk("R5 write other bank", 0, 0, 0);
    issue(P_PRE, 0, 1'b0);                      // k+4, sees recovery
    flag_chk("R5 pre busy bank in recovery", 1, C_PRE, 0);
    issue(P_PRE, 1, 1'b0);                      // k+5, all idle again
    flag_chk("R5 pre other bank", 0, 0, 0);
    chk("R5 bank1 closed", bst(1), S_IDLE);
  endtask

  task automatic t_global();
    do_reset();
    issue(P_ACT, 0, 1'b0); nop();
    issue(P_ACT, 1, 1'b0); nop();
    issue(P_WR, 0, 1'b1);                       // edge k
    issue(P_BST, 2, 1'b0);                      // k+1
    flag_chk("R4 bst in burst", 1, C_BST, 2);
    issue(P_REF, 0, 1'b0);                      // k+2
    flag_chk("R4 ref in burst", 1, C_REF, 0);
    chk("R10 no refresh entered", bst(1), S_OPEN);
    issue(P_MRS, 3, 1'b0);                      // k+3
    flag_chk("R4 mrs in burst", 1, C_MRS, 3);
    issue(P_PRE, 1, 1'b1);                      // k+4
    flag_chk("R5 pre-all in recovery", 1, C_PRE, 1);
    chk("R10 bank1 still open", bst(1), S_OPEN);
    issue(P_DESL, 0, 1'b0);                     // k+5
    flag_chk("R4 deselect", 0, 0, 0);
  endtask

  task automatic t_rrd();
    do_reset();
    issue(P_ACT, 0, 1'b0);                      // e0
    nop();
    issue(P_WR, 0, 1'b1);                       // k = e0+2
    issue(P_ACT, 1, 1'b0);                      // k+1
    flag_chk("R6 act other bank spaced", 0, 0, 0);
    chk("R6 bank1 opened", bst(1), S_OPEN);
    issue(P_ACT, 2, 1'b0);                      // k+2
    flag_chk("R6 act too close", 1, C_ACT, 2);
    chk("R10 bank2 not opened", bst(2), S_IDLE);
    issue(P_ACT, 2, 1'b0);                      // k+3
    flag_chk("R10 count not restarted", 0, 0, 0);
    chk("R6 bank2 opened", bst(2), S_OPEN);
    issue(P_ACT, 0, 1'b0);                      // k+4, bank0 in recovery
    flag_chk("R6 act busy bank", 1, C_ACT, 0);
  endtask

  task automatic t_refresh();
    do_reset();
    issue(P_REF, 0, 1'b0);                      // edge r
    for (int i = 0; i < NB; i++) chk($sformatf("R7 bank%0d refresh", i), bst(i), S_RF);
    nop();                                      // r+1
    flag_chk("R8 nop in refresh", 0, 0, 0);
    issue(P_BST, 1, 1'b0);                      // r+2
    flag_chk("R8 bst in refresh", 0, 0, 0);
    issue(P_ACT, 3, 1'b0);                      // r+3
    flag_chk("R8 act in refresh", 1, C_ACT, 3);
    chk("R10 bank3 stays refresh", bst(3), S_RF);
    issue(P_RD, 1, 1'b0);                       // r+4
    flag_chk("R8 read in refresh", 1, C_RD, 1);
    chk("R7 still refresh r+4", bst(2), S_RF);
    issue(P_MRS, 2, 1'b0);                      // r+5 = r+RC-1
    flag_chk("R8 mrs in refresh", 1, C_MRS, 2);
    chk("R7 idle after tRC", int'(bank_state), 0);
    issue(P_ACT, 3, 1'b0);                      // r+6
    flag_chk("R7 act after tRC", 0, 0, 0);
    chk("R7 bank3 opened", bst(3), S_OPEN);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_open_close();
    t_wburst();
    t_same_bank();
    t_global();
    t_rrd();
    t_refresh();
    summary();
    $finish;
  end

endmodule